// File: doc/BRIEF.md
# Processor Status Byte with Interrupt Qualification

This block holds the eight-bit status byte of a small processor. The low three bits are the arithmetic flags: negative, carry and zero. Bit 3 is the interrupt-enable bit. The four upper bits are general purpose, and hardware outside the core can set or clear them directly.

The execute unit sends the block flag updates, single-bit write commands, interrupt-taken strobes and whole-byte restores. All of these land on one clock edge, and the block resolves them in a fixed priority. The block also turns any one status bit, picked by a three-bit index, into a branch condition for a branch-if-zero or branch-if-one test.

Eight interrupt request lines are qualified against the enable bit. Line 0 is never masked. When several qualified requests are present, the lowest-numbered line wins, and its index is reported beside a pending flag. Vector fetch and stacking are handled elsewhere.

The block has no state machine. Each cycle it computes the next byte from the current byte and the commands present, then registers it. The only transitions are reset, which clears the byte, and the clock edge, which loads the next byte.

Top module: `status_irq_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight status bits to 0. A qualified request from line 0 still drives `irq_pending_o` high with index 0 during reset.
- R2: When `flag_we` is high, `flag_nzc` = {N,C,Z} loads bits 2, 1 and 0. Bits not otherwise written keep their value.
- R3: When `bit_cmd_en` is high, `bit_cmd_val` is written to the status bit numbered `bit_sel` (0 to 7). On the same bit this command overrides a flag update.
- R4: `ext_set[k]` sets, and `ext_clr[k]`, clears status bit 4+k. A set wins over a clear on the same bit in the same cycle. Both win over a bit command on bits 7:4.
- R5: `irq_take` sets bit 3 (interrupt enable), overriding a bit command that would clear it.
- R6: `restore_we` loads `restore_val` into the whole byte and overrides every other update in that cycle.
- R7: `cond_o` is 1 exactly when status bit `test_sel` equals `test_pol` (0 = branch-if-zero, 1 = branch-if-one). It is computed from the registered byte in the same cycle.
- R8: Request line 0 qualifies regardless of bit 3. Lines 7 to 1 qualify only while bit 3 is 1.
- R9: `irq_pending_o` is 1 when any line qualifies, and `irq_index_o` is the lowest qualified line number. When no line qualifies, both are 0.
- R10: Updates appear on `status_o` only after the rising clock edge that samples them, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Load the N, C and Z flags |
| flag_nzc | input | 3 | New {N,C,Z} values |
| bit_cmd_en | input | 1 | Single-bit write command |
| bit_sel | input | 3 | Bit number for the bit command |
| bit_cmd_val | input | 1 | Value written by the bit command |
| ext_set | input | 4 | External set for bits 7:4 |
| ext_clr | input | 4 | External clear for bits 7:4 |
| irq_take | input | 1 | Interrupt taken; sets the enable bit |
| restore_we | input | 1 | Whole-byte restore strobe |
| restore_val | input | 8 | Byte to restore |
| irq_lines | input | 8 | Interrupt request lines |
| test_sel | input | 3 | Status bit picked for the branch condition |
| test_pol | input | 1 | Polarity tested: 1 = branch-if-one |
| status_o | output | 8 | Registered status byte |
| cond_o | output | 1 | Branch condition result |
| irq_pending_o | output | 1 | A qualified request exists |
| irq_index_o | output | 3 | Lowest qualified request line |

## Verification
Request patterns are run with the enable bit both low and high. The patterns are: no lines, line 0 alone, only the maskable lines, a lone top line, line 0 together with a high line, and a scattered middle pair. Together these separate masking from the non-maskable bypass, and lowest-first priority from highest-first.

Status-byte updates are driven in pairs that collide on the same bit. The collisions are flag update against bit command, set against clear, external input against bit command, interrupt taken against a clearing command, and restore against everything. This shows the priority order, not just each path on its own.

Branch conditions are probed on a set and a clear bit under both polarities.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W     = 8;
    localparam int SEL_W     = $clog2(PSR_W);
    localparam int POS_Z     = 0;
    localparam int POS_C     = 1;
    localparam int POS_N     = 2;
    localparam int POS_IE    = 3;
    localparam int GP_LO     = 4;
    localparam int GP_W      = PSR_W - GP_LO;
    localparam int IRQ_N     = 8;
    localparam int IRQ_IDX_W = $clog2(IRQ_N);
endpackage

// File: rtl/psr_bits.sv
module psr_bits
    import psr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flag_we,
    input  logic [2:0]         flag_nzc,
    input  logic               bit_cmd_en,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic               bit_cmd_val,
    input  logic [GP_W-1:0]    ext_set,
    input  logic [GP_W-1:0]    ext_clr,
    input  logic               irq_take,
    input  logic               restore_we,
    input  logic [PSR_W-1:0]   restore_val,
    output logic [PSR_W-1:0]   q
);
    logic [PSR_W-1:0] nxt;

    // Lowest priority first; each later step may override.
    always_comb begin
        nxt = q;
        if (flag_we) begin
            nxt[POS_N] = flag_nzc[2];
            nxt[POS_C] = flag_nzc[1];
            nxt[POS_Z] = flag_nzc[0];
        end
        if (bit_cmd_en) begin
            nxt[bit_sel] = bit_cmd_val;
        end
        if (irq_take) begin
            nxt[POS_IE] = 1'b1;
        end
        for (int k = 0; k < GP_W; k++) begin
            if (ext_set[k]) begin
                nxt[GP_LO+k] = 1'b1;
            end else if (ext_clr[k]) begin
                nxt[GP_LO+k] = 1'b0;
            end
        end
        if (restore_we) begin
            nxt = restore_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (q == '0));

    p_restore_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(restore_we)) |-> (q == $past(restore_val)));

    p_ext_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restore_we))
        |-> ((q[PSR_W-1:GP_LO] & $past(ext_set)) == $past(ext_set)));

    p_ext_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restore_we))
        |-> ((q[PSR_W-1:GP_LO] & ($past(ext_clr) & ~$past(ext_set))) == '0));

    p_take_sets_ie_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restore_we) && $past(irq_take)) |-> q[POS_IE]);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flag_we) && !$past(bit_cmd_en) && !$past(irq_take)
         && !$past(restore_we) && ($past(ext_set) == '0) && ($past(ext_clr) == '0))
        |-> $stable(q));
endmodule

// File: rtl/psr_cond.sv
module psr_cond
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0] status,
    input  logic [SEL_W-1:0] test_sel,
    input  logic             test_pol,
    output logic             cond
);
    always_comb begin
        cond = (status[test_sel] == test_pol);
    end
endmodule

// File: rtl/irq_qual.sv
module irq_qual
    import psr_pkg::*;
#(
    parameter int N     = IRQ_N,
    localparam int IW   = $clog2(N)
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic         ie,
    output logic         pending,
    output logic [IW-1:0] index
);
    logic [N-1:0] masked;

    generate
        for (genvar g = 0; g < N; g++) begin : g_mask
            if (g == 0) begin : g_nmi
                assign masked[g] = lines[g];
            end else begin : g_maskable
                assign masked[g] = lines[g] & ie;
            end
        end
    endgenerate

    always_comb begin
        index = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (masked[k]) begin
                index = IW'(k);
            end
        end
        pending = |masked;
    end

    p_line0_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        lines[0] |-> (pending && (index == '0)));

    p_masked_off_r8: assert property (@(posedge clk) disable iff (rst)
        !ie |-> (pending == lines[0]));

    p_none_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !pending |-> (index == '0));

    p_winner_live_r9: assert property (@(posedge clk) disable iff (rst)
        pending |-> lines[index]);
endmodule

// File: rtl/status_irq_unit.sv
module status_irq_unit
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  logic [2:0]       flag_nzc,
    input  logic             bit_cmd_en,
    input  logic [2:0]       bit_sel,
    input  logic             bit_cmd_val,
    input  logic [3:0]       ext_set,
    input  logic [3:0]       ext_clr,
    input  logic             irq_take,
    input  logic             restore_we,
    input  logic [7:0]       restore_val,
    input  logic [7:0]       irq_lines,
    input  logic [2:0]       test_sel,
    input  logic             test_pol,
    output logic [7:0]       status_o,
    output logic             cond_o,
    output logic             irq_pending_o,
    output logic [2:0]       irq_index_o
);
    logic [PSR_W-1:0] psr_q;

    psr_bits u_bits (
        .clk         (clk),
        .rst         (rst),
        .flag_we     (flag_we),
        .flag_nzc    (flag_nzc),
        .bit_cmd_en  (bit_cmd_en),
        .bit_sel     (bit_sel),
        .bit_cmd_val (bit_cmd_val),
        .ext_set     (ext_set),
        .ext_clr     (ext_clr),
        .irq_take    (irq_take),
        .restore_we  (restore_we),
        .restore_val (restore_val),
        .q           (psr_q)
    );

    psr_cond u_cond (
        .status   (psr_q),
        .test_sel (test_sel),
        .test_pol (test_pol),
        .cond     (cond_o)
    );

    irq_qual #(.N(IRQ_N)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .ie      (psr_q[POS_IE]),
        .pending (irq_pending_o),
        .index   (irq_index_o)
    );

    assign status_o = psr_q;

    p_cond_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        (cond_o == (status_o[test_sel] == test_pol)) || $isunknown(test_sel));
endmodule

// File: tb/status_irq_unit_bench.sv
module status_irq_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flag_we = 1'b0;
    logic [2:0] flag_nzc = '0;
    logic       bit_cmd_en = 1'b0;
    logic [2:0] bit_sel = '0;
    logic       bit_cmd_val = 1'b0;
    logic [3:0] ext_set = '0;
    logic [3:0] ext_clr = '0;
    logic       irq_take = 1'b0;
    logic       restore_we = 1'b0;
    logic [7:0] restore_val = '0;
    logic [7:0] irq_lines = '0;
    logic [2:0] test_sel = '0;
    logic       test_pol = 1'b0;
    logic [7:0] status_o;
    logic       cond_o;
    logic       irq_pending_o;
    logic [2:0] irq_index_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    status_irq_unit u_status_irq_unit (
        .clk(clk), .rst(rst), .flag_we(flag_we), .flag_nzc(flag_nzc),
        .bit_cmd_en(bit_cmd_en), .bit_sel(bit_sel), .bit_cmd_val(bit_cmd_val),
        .ext_set(ext_set), .ext_clr(ext_clr), .irq_take(irq_take),
        .restore_we(restore_we), .restore_val(restore_val), .irq_lines(irq_lines),
        .test_sel(test_sel), .test_pol(test_pol), .status_o(status_o),
        .cond_o(cond_o), .irq_pending_o(irq_pending_o), .irq_index_o(irq_index_o)
    );

    // {ie, lines, expected pending, expected index}
    localparam int NV = 9;
    localparam logic [12:0] IRQ_VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 3'd0},
        {1'b0, 8'h01, 1'b1, 3'd0},
        {1'b0, 8'hFE, 1'b0, 3'd0},
        {1'b1, 8'hFE, 1'b1, 3'd1},
        {1'b1, 8'h80, 1'b1, 3'd7},
        {1'b1, 8'h81, 1'b1, 3'd0},
        {1'b1, 8'h28, 1'b1, 3'd3},
        {1'b0, 8'h81, 1'b1, 3'd0},
        {1'b1, 8'h00, 1'b0, 3'd0}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_cmds();
        flag_we = 1'b0; bit_cmd_en = 1'b0; ext_set = '0; ext_clr = '0;
        irq_take = 1'b0; restore_we = 1'b0;
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) step();
        chk8("R1 status in reset", status_o, 8'h00);
        rst = 1'b0;
        step();
        chk8("R1 status after reset", status_o, 8'h00);
        chk8("R9 idle pending", {7'b0, irq_pending_o}, 8'h00);

        // Table walk: R8 masking and R9 priority
        for (int i = 0; i < NV; i++) begin
            restore_we = 1'b1;
            restore_val = IRQ_VEC[i][12] ? 8'h08 : 8'h00;
            step();
            restore_we = 1'b0;
            irq_lines = IRQ_VEC[i][11:4];
            #1;
            chk8($sformatf("R8 pending vec%0d", i), {7'b0, irq_pending_o}, {7'b0, IRQ_VEC[i][3]});
            chk8($sformatf("R9 index vec%0d", i), {5'b0, irq_index_o}, {5'b0, IRQ_VEC[i][2:0]});
        end
        irq_lines = '0;
        restore_we = 1'b1; restore_val = 8'h00;
        step();
        clear_cmds();

        // R2 flag load; R10 no change before edge
        flag_we = 1'b1; flag_nzc = 3'b101;
        #1;
        chk8("R10 before edge", status_o, 8'h00);
        step();
        chk8("R2 flag load", status_o, 8'h05);
        // R3 bit command overrides flag on bit 0
        flag_nzc = 3'b011; bit_cmd_en = 1'b1; bit_sel = 3'd0; bit_cmd_val = 1'b0;
        step();
        chk8("R3 bit cmd over flag", status_o, 8'h02);
        clear_cmds();
        bit_cmd_en = 1'b1; bit_sel = 3'd6; bit_cmd_val = 1'b1;
        step();
        chk8("R3 set bit 6", status_o, 8'h42);
        clear_cmds();

        // R4 external set/clear
        ext_set = 4'b0001; ext_clr = 4'b0100;
        step();
        chk8("R4 ext set/clr", status_o, 8'h12);
        ext_set = 4'b1000; ext_clr = 4'b1000;
        step();
        chk8("R4 set wins", status_o, 8'h92);
        ext_set = '0; ext_clr = 4'b1000; bit_cmd_en = 1'b1; bit_sel = 3'd7; bit_cmd_val = 1'b1;
        step();
        chk8("R4 ext over bit cmd", status_o, 8'h12);
        clear_cmds();

        // R5 take overrides clearing command on bit 3
        irq_take = 1'b1; bit_cmd_en = 1'b1; bit_sel = 3'd3; bit_cmd_val = 1'b0;
        step();
        chk8("R5 take sets IE", status_o, 8'h1A);
        clear_cmds();

        // R7 branch condition on 0x1A
        test_sel = 3'd3; test_pol = 1'b1; #1;
        chk8("R7 bit3 one", {7'b0, cond_o}, 8'h01);
        test_pol = 1'b0; #1;
        chk8("R7 bit3 zero", {7'b0, cond_o}, 8'h00);
        test_sel = 3'd5; #1;
        chk8("R7 bit5 zero", {7'b0, cond_o}, 8'h01);

        // R6 restore overrides all
        restore_we = 1'b1; restore_val = 8'hA5; ext_set = 4'hF; flag_we = 1'b1;
        flag_nzc = 3'b010; irq_take = 1'b0; bit_cmd_en = 1'b1; bit_sel = 3'd0; bit_cmd_val = 1'b0;
        step();
        chk8("R6 restore wins", status_o, 8'hA5);
        clear_cmds();

        // R1 reset mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk8("R1 reset mid-run", status_o, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule